// File: doc/BRIEF.md
# Prevalidated One-Hot Cache Tag Array

This block is the tag store of a set-associative level-1 data cache in which a line's tag is not a physical address. Each way of each set holds a 32-bit vector with exactly one bit set. That bit names the TLB entry whose translation covers the line. A lookup therefore needs no address comparison. The live TLB match vector for the access is ANDed with each stored vector at the selected set, and a way hits when any bit survives and the way is valid.

Two read ports look up independently in the same cycle. Each port returns one hit bit per way, a flag for a corrupted (multi-hot) stored vector, and a flag for more than one hitting way. A fill port writes a new vector into one way and validates it. When a TLB entry is retired, an invalidate port takes a mask of retired entries and, in one clock edge, clears the valid bit of every tag in every set whose vector touches that mask. The cache is write-through, so dropping a line is always safe. This covers invalidation after a detected error as well as TLB retirement.

Data storage, victim choice and fill sequencing sit outside this block.

Top module: `tagpv_array`

## Requirements
- R1: While `rst` is high, every entry becomes invalid and all read outputs are 0. A read after reset finds no hit in any set for any match vector.
- R2: A fill with `fill_en` high stores `fill_vec` into set `fill_set`, way `fill_way` and marks it valid. A later fill to the same entry replaces the old vector. Other entries keep their contents.
- R3: A read with `rdN_en` high at a clock edge presents results after that edge. Bit w of `rdN_hit` is 1 exactly when way w at set `rdN_set` is valid, its stored vector has at most one bit set, and that vector ANDed with `rdN_match` is nonzero. Bit i of a vector stands for TLB entry i, and bit w of a hit output stands for way w.
- R4: A read port whose enable is low at an edge shows all hit bits and both flags at 0 after that edge.
- R5: The two read ports are independent. Each uses only its own enable, set and match inputs in the same cycle.
- R6: When any valid way at the read set stores a vector with two or more bits set, `rdN_mhot` is 1 and that way reports a miss. A valid all-zero vector never hits and raises no flag.
- R7: `rdN_conflict` is 1 exactly when two or more hit bits are 1. The hit bits are still reported unchanged. With `rdN_conflict` at 0, at most one hit bit is 1.
- R8: With `inv_en` high at an edge, every entry in every set whose stored vector shares a set bit with `inv_mask` becomes invalid at that edge. Entries with no shared bit are unaffected.
- R9: A read at the same edge as a fill or invalidate sees the contents from before that edge. When a fill and an invalidate hit the same entry at one edge, the fill wins and the entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_set | input | 6 | Read port 0 set index |
| rd0_match | input | 32 | Read port 0 TLB match vector |
| rd0_hit | output | 4 | Read port 0 per-way hit, registered |
| rd0_mhot | output | 1 | Read port 0 multi-hot vector seen |
| rd0_conflict | output | 1 | Read port 0 more than one way hit |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_set | input | 6 | Read port 1 set index |
| rd1_match | input | 32 | Read port 1 TLB match vector |
| rd1_hit | output | 4 | Read port 1 per-way hit, registered |
| rd1_mhot | output | 1 | Read port 1 multi-hot vector seen |
| rd1_conflict | output | 1 | Read port 1 more than one way hit |
| fill_en | input | 1 | Fill write enable |
| fill_set | input | 6 | Fill set index |
| fill_way | input | 2 | Fill way |
| fill_vec | input | 32 | One-hot TLB pointer to store |
| inv_en | input | 1 | Bulk invalidate enable |
| inv_mask | input | 32 | Retired TLB entries, one bit each |

## Verification
A stale or wrong vector or valid bit shows at the ports on the first read of that set, one edge after the read is issued. It appears as a missing or extra hit bit, or as a stray multi-hot or conflict flag. A bulk invalidate that misses an entry, or clears one too many, is caught by reads to sets the mask should and should not have touched. Reads issued on the very edge of a fill or invalidate check that the results reflect the contents from before that edge.

// File: rtl/tagpv_pkg.sv
`timescale 1ns/1ps
package tagpv_pkg;

    localparam int NUM_RD = 2;
    localparam int MAX_VEC = 64;

    // True when the vector has two or more bits set.
    function automatic logic over_one(input logic [MAX_VEC-1:0] v);
        return (v & (v - MAX_VEC'(1))) != '0;
    endfunction

endpackage

// File: rtl/tagpv_store.sv
`timescale 1ns/1ps
module tagpv_store #(
    parameter int SETS = 64,
    parameter int WAYS = 4,
    parameter int TLBN = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int NRD = tagpv_pkg::NUM_RD
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          fill_en,
    input  logic [SET_W-1:0]              fill_set,
    input  logic [WAY_W-1:0]              fill_way,
    input  logic [TLBN-1:0]               fill_vec,
    input  logic                          inv_en,
    input  logic [TLBN-1:0]               inv_mask,
    input  logic [SET_W-1:0]              rd_set   [NRD],
    output logic [WAYS-1:0][TLBN-1:0]     row_vec  [NRD],
    output logic [WAYS-1:0]               row_vld  [NRD]
);

    logic [WAYS-1:0][TLBN-1:0] vec_q [SETS];
    logic [WAYS-1:0]           vld_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                vec_q[s] <= '0;
            end
        end else begin
            // Bulk purge of every entry pointing at a retired TLB slot.
            if (inv_en) begin
                for (int s = 0; s < SETS; s++) begin
                    for (int w = 0; w < WAYS; w++) begin
                        if ((vec_q[s][w] & inv_mask) != '0)
                            vld_q[s][w] <= 1'b0;
                    end
                end
            end
            // Fill is placed last so it overrides a purge of its own entry.
            if (fill_en) begin
                vec_q[fill_set][fill_way] <= fill_vec;
                vld_q[fill_set][fill_way] <= 1'b1;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign row_vec[p] = vec_q[rd_set[p]];
        assign row_vld[p] = vld_q[rd_set[p]];
    end

endmodule

// File: rtl/tagpv_lookup.sv
`timescale 1ns/1ps
module tagpv_lookup #(
    parameter int WAYS = 4,
    parameter int TLBN = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic [TLBN-1:0]           match,
    input  logic [WAYS-1:0][TLBN-1:0] row_vec,
    input  logic [WAYS-1:0]           row_vld,
    output logic [WAYS-1:0]           hit_q,
    output logic                      mhot_q,
    output logic                      conflict_q
);

    logic [WAYS-1:0] way_multi;
    logic [WAYS-1:0] way_hit;
    logic            mhot_c;
    logic            conflict_c;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_multi[w] = tagpv_pkg::over_one(tagpv_pkg::MAX_VEC'(row_vec[w]));
        assign way_hit[w]   = en && row_vld[w] && !way_multi[w]
                              && ((row_vec[w] & match) != '0);
    end

    assign mhot_c     = en && ((row_vld & way_multi) != '0);
    assign conflict_c = (way_hit & (way_hit - WAYS'(1))) != '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q      <= '0;
            mhot_q     <= 1'b0;
            conflict_q <= 1'b0;
        end else begin
            hit_q      <= way_hit;
            mhot_q     <= mhot_c;
            conflict_q <= conflict_c;
        end
    end

endmodule

// File: rtl/tagpv_array.sv
`timescale 1ns/1ps
module tagpv_array #(
    parameter int SETS = 64,
    parameter int WAYS = 4,
    parameter int TLBN = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd0_en,
    input  logic [SET_W-1:0] rd0_set,
    input  logic [TLBN-1:0]  rd0_match,
    output logic [WAYS-1:0]  rd0_hit,
    output logic             rd0_mhot,
    output logic             rd0_conflict,
    input  logic             rd1_en,
    input  logic [SET_W-1:0] rd1_set,
    input  logic [TLBN-1:0]  rd1_match,
    output logic [WAYS-1:0]  rd1_hit,
    output logic             rd1_mhot,
    output logic             rd1_conflict,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [TLBN-1:0]  fill_vec,
    input  logic             inv_en,
    input  logic [TLBN-1:0]  inv_mask
);

    localparam int NRD = tagpv_pkg::NUM_RD;

    logic                      p_en     [NRD];
    logic [SET_W-1:0]          p_set    [NRD];
    logic [TLBN-1:0]           p_match  [NRD];
    logic [WAYS-1:0][TLBN-1:0] p_vec    [NRD];
    logic [WAYS-1:0]           p_vld    [NRD];
    logic [WAYS-1:0]           p_hit    [NRD];
    logic                      p_mhot   [NRD];
    logic                      p_conf   [NRD];

    assign p_en[0]    = rd0_en;
    assign p_set[0]   = rd0_set;
    assign p_match[0] = rd0_match;
    assign p_en[1]    = rd1_en;
    assign p_set[1]   = rd1_set;
    assign p_match[1] = rd1_match;

    assign rd0_hit      = p_hit[0];
    assign rd0_mhot     = p_mhot[0];
    assign rd0_conflict = p_conf[0];
    assign rd1_hit      = p_hit[1];
    assign rd1_mhot     = p_mhot[1];
    assign rd1_conflict = p_conf[1];

    tagpv_store #(.SETS(SETS), .WAYS(WAYS), .TLBN(TLBN)) u_store (
        .clk      (clk),
        .rst      (rst),
        .fill_en  (fill_en),
        .fill_set (fill_set),
        .fill_way (fill_way),
        .fill_vec (fill_vec),
        .inv_en   (inv_en),
        .inv_mask (inv_mask),
        .rd_set   (p_set),
        .row_vec  (p_vec),
        .row_vld  (p_vld)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_port
        tagpv_lookup #(.WAYS(WAYS), .TLBN(TLBN)) u_look (
            .clk        (clk),
            .rst        (rst),
            .en         (p_en[p]),
            .match      (p_match[p]),
            .row_vec    (p_vec[p]),
            .row_vld    (p_vld[p]),
            .hit_q      (p_hit[p]),
            .mhot_q     (p_mhot[p]),
            .conflict_q (p_conf[p])
        );
    end

endmodule

// File: rtl/tagpv_checks.sv
`timescale 1ns/1ps
module tagpv_checks #(
    parameter int SETS = 64,
    parameter int WAYS = 4,
    parameter int TLBN = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst,
    input logic             rd0_en,
    input logic [SET_W-1:0] rd0_set,
    input logic [TLBN-1:0]  rd0_match,
    input logic [WAYS-1:0]  rd0_hit,
    input logic             rd0_mhot,
    input logic             rd0_conflict,
    input logic             rd1_en,
    input logic [SET_W-1:0] rd1_set,
    input logic [TLBN-1:0]  rd1_match,
    input logic [WAYS-1:0]  rd1_hit,
    input logic             rd1_mhot,
    input logic             rd1_conflict,
    input logic             fill_en,
    input logic [SET_W-1:0] fill_set,
    input logic [WAY_W-1:0] fill_way,
    input logic [TLBN-1:0]  fill_vec,
    input logic             inv_en,
    input logic [TLBN-1:0]  inv_mask
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rd0_hit == '0 && rd1_hit == '0 && !rd0_mhot && !rd1_mhot));

    p_fill_then_hit_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(fill_en) && rd0_en && rd0_set == $past(fill_set)
         && rd0_match == $past(fill_vec) && $countones($past(fill_vec)) == 1)
        |=> rd0_hit[$past(fill_way, 2)]);

    p_idle0_r4: assert property (@(posedge clk) disable iff (rst)
        !rd0_en |=> (rd0_hit == '0 && !rd0_mhot && !rd0_conflict));

    p_idle1_r4: assert property (@(posedge clk) disable iff (rst)
        !rd1_en |=> (rd1_hit == '0 && !rd1_mhot && !rd1_conflict));

    p_single0_r7: assert property (@(posedge clk) disable iff (rst)
        !rd0_conflict |-> $onehot0(rd0_hit));

    p_single1_r7: assert property (@(posedge clk) disable iff (rst)
        !rd1_conflict |-> $onehot0(rd1_hit));

    p_conflict_cnt_r7: assert property (@(posedge clk) disable iff (rst)
        (rd0_conflict |-> $countones(rd0_hit) > 1) and (rd1_conflict |-> $countones(rd1_hit) > 1));

    // R8: a valid-only match against a purged one-hot pointer cannot hit next read.
    p_purge_r8: assert property (@(posedge clk) disable iff (rst)
        (inv_en && !fill_en && rd0_en && rd0_match == inv_mask && $countones(inv_mask) == 1)
        ##1 (rd0_en && $past(rd0_set) == rd0_set && $past(rd0_match) == rd0_match && !$past(fill_en))
        |=> rd0_hit == '0);

endmodule

bind tagpv_array tagpv_checks #(.SETS(SETS), .WAYS(WAYS), .TLBN(TLBN)) u_chk (.*);

// File: tb/tagpv_array_test.sv
`timescale 1ns/1ps
module tagpv_array_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd0_en = 0, rd1_en = 0;
    logic [5:0]  rd0_set = 0, rd1_set = 0;
    logic [31:0] rd0_match = 0, rd1_match = 0;
    logic [3:0]  rd0_hit, rd1_hit;
    logic        rd0_mhot, rd1_mhot, rd0_conflict, rd1_conflict;
    logic        fill_en = 0;
    logic [5:0]  fill_set = 0;
    logic [1:0]  fill_way = 0;
    logic [31:0] fill_vec = 0;
    logic        inv_en = 0;
    logic [31:0] inv_mask = 0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tagpv_array uut (.*);

    typedef struct packed {
        logic [5:0]  s0; logic [31:0] m0; logic [3:0] h0; logic mh0; logic cf0;
        logic [5:0]  s1; logic [31:0] m1; logic [3:0] h1; logic mh1; logic cf1;
    } rdv_t;

    localparam int NV = 7;
    localparam rdv_t TBL [NV] = '{
        '{6'd5,  32'h0000_0008, 4'b0001, 1'b0, 1'b0,  6'd63, 32'h8000_0000, 4'b1000, 1'b0, 1'b0},
        '{6'd5,  32'h0000_0080, 4'b0010, 1'b0, 1'b0,  6'd5,  32'h0000_0088, 4'b0011, 1'b0, 1'b1},
        '{6'd9,  32'h0000_0008, 4'b0000, 1'b1, 1'b0,  6'd9,  32'h0000_0000, 4'b0000, 1'b1, 1'b0},
        '{6'd0,  32'h0000_0001, 4'b0100, 1'b0, 1'b0,  6'd0,  32'h0000_0002, 4'b0000, 1'b0, 1'b0},
        '{6'd63, 32'hFFFF_FFFF, 4'b1000, 1'b0, 1'b0,  6'd5,  32'h0000_0000, 4'b0000, 1'b0, 1'b0},
        '{6'd6,  32'hFFFF_FFFF, 4'b0000, 1'b0, 1'b0,  6'd4,  32'hFFFF_FFFF, 4'b0000, 1'b0, 1'b0},
        '{6'd12, 32'h0000_0010, 4'b1001, 1'b0, 1'b1,  6'd12, 32'h0000_0020, 4'b0000, 1'b0, 1'b0}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_p0(input string req, input logic [3:0] h, input logic mh, input logic cf);
        chk(req, "p0 hit", 32'(rd0_hit), 32'(h));
        chk(req, "p0 mhot", 32'(rd0_mhot), 32'(mh));
        chk(req, "p0 conflict", 32'(rd0_conflict), 32'(cf));
    endtask

    task automatic chk_p1(input string req, input logic [3:0] h, input logic mh, input logic cf);
        chk(req, "p1 hit", 32'(rd1_hit), 32'(h));
        chk(req, "p1 mhot", 32'(rd1_mhot), 32'(mh));
        chk(req, "p1 conflict", 32'(rd1_conflict), 32'(cf));
    endtask

    task automatic fill(input logic [5:0] s, input logic [1:0] w, input logic [31:0] v);
        fill_en = 1; fill_set = s; fill_way = w; fill_vec = v;
        step();
        fill_en = 0;
    endtask

    task automatic read0(input logic [5:0] s, input logic [31:0] m);
        rd0_en = 1; rd0_set = s; rd0_match = m;
        step();
        rd0_en = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R1: outputs quiet during reset, even with reads requested
        rd0_en = 1; rd0_match = '1; rd1_en = 1; rd1_match = '1;
        repeat (3) step();
        chk_p0("R1", 4'b0000, 0, 0);
        chk_p1("R1", 4'b0000, 0, 0);
        rst = 0;
        step();
        // R1: nothing valid after reset
        chk_p0("R1", 4'b0000, 0, 0);
        chk_p1("R1", 4'b0000, 0, 0);
        rd0_en = 0; rd1_en = 0;

        // R2: populate entries
        fill(6'd5,  2'd0, 32'h0000_0008);
        fill(6'd5,  2'd1, 32'h0000_0080);
        fill(6'd9,  2'd2, 32'h0000_0208);
        fill(6'd63, 2'd3, 32'h8000_0000);
        fill(6'd0,  2'd2, 32'h0000_0001);
        fill(6'd12, 2'd0, 32'h0000_0010);
        fill(6'd12, 2'd3, 32'h0000_0010);
        fill(6'd7,  2'd1, 32'h0000_0000);

        // R3 R5 R6 R7: vector table, both ports each cycle
        for (int i = 0; i < NV; i++) begin
            rd0_en = 1; rd0_set = TBL[i].s0; rd0_match = TBL[i].m0;
            rd1_en = 1; rd1_set = TBL[i].s1; rd1_match = TBL[i].m1;
            step();
            chk_p0("R3", TBL[i].h0, TBL[i].mh0, TBL[i].cf0);
            chk_p1("R5", TBL[i].h1, TBL[i].mh1, TBL[i].cf1);
        end

        // R6: all-zero valid vector never hits and raises no flag
        rd0_set = 6'd7; rd0_match = '1;
        step();
        chk_p0("R6", 4'b0000, 0, 0);

        // R4: port 0 idle while port 1 reads; R5 independence
        rd0_en = 0; rd0_set = 6'd5; rd0_match = 32'h8;
        rd1_set = 6'd5; rd1_match = 32'h8;
        step();
        chk_p0("R4", 4'b0000, 0, 0);
        chk_p1("R5", 4'b0001, 0, 0);
        rd1_en = 0;
        step();
        chk_p1("R4", 4'b0000, 0, 0);

        // R9: read on the same edge as a fill sees old contents
        fill_en = 1; fill_set = 6'd20; fill_way = 2'd1; fill_vec = 32'h0000_0800;
        rd0_en = 1; rd0_set = 6'd20; rd0_match = 32'h0000_0800;
        step();
        fill_en = 0;
        chk_p0("R9", 4'b0000, 0, 0);
        step();
        chk_p0("R2", 4'b0010, 0, 0);
        rd0_en = 0;

        // R8: purge TLB entry 3 across all sets
        inv_en = 1; inv_mask = 32'h0000_0008;
        rd0_en = 1; rd0_set = 6'd5; rd0_match = 32'h8;
        step();
        inv_en = 0;
        chk_p0("R9", 4'b0001, 0, 0);
        step();
        chk_p0("R8", 4'b0000, 0, 0);
        read0(6'd9, 32'hFFFF_FFFF);
        chk_p0("R8", 4'b0000, 0, 0);
        read0(6'd5, 32'h0000_0080);
        chk_p0("R8", 4'b0010, 0, 0);
        read0(6'd12, 32'h0000_0010);
        chk_p0("R8", 4'b1001, 0, 1);

        // R9: fill and purge of the same entry on one edge, fill wins
        fill_en = 1; fill_set = 6'd21; fill_way = 2'd0; fill_vec = 32'h0000_1000;
        inv_en = 1; inv_mask = 32'h0000_1000;
        step();
        fill_en = 0; inv_en = 0;
        read0(6'd21, 32'h0000_1000);
        chk_p0("R9", 4'b0001, 0, 0);

        // R2: overwrite replaces the old pointer
        fill(6'd5, 2'd1, 32'h0000_0100);
        read0(6'd5, 32'h0000_0080);
        chk_p0("R2", 4'b0000, 0, 0);
        read0(6'd5, 32'h0000_0100);
        chk_p0("R2", 4'b0010, 0, 0);

        step();
        finish_run();
    end

endmodule